// File: doc/BRIEF.md
# Fault Alert Gatherer

This block collects single-cycle event strobes from the ports of a power controller into sticky status bits. It combines them with a host-written enable vector to drive the enable of an active-low open-drain alert line: when `irq_oe_o` is high, the pad pulls the line low. Every strobe is recorded in status, including strobes from sources the host has disabled. Only a freshly arriving enabled event can raise the alert.

The block also watches the serial control bus so that it never pulls the alert line in the middle of a transfer. An enabled event that arrives while a transfer is in progress is held back until a stop condition is seen, and is then signalled on the following clock. If the line is already low when a transfer begins, it stays low. When the host reads the alert-response address, the line is released while status is left intact. The line asserts again as soon as another enabled event arrives. The host clears status one bit at a time or all bits at once. The line also drops when no enabled status bit remains set.

Top module: `alert_gather`

## Requirements
- R1: While `rst_n` is low and after its release, `status_o` is all zeros and `irq_oe_o` is 0.
- R2: A strobe on `evt_i[k]` sets `status_o[k]` on the next clock, whatever the value of `irq_en_i[k]`.
- R3: A status bit stays set until `clr_i[k]` or `clr_all_i` is sampled high. A strobe on the same bit in the same cycle wins over either clear.
- R4: With `bus_busy_i` low and no deferred alert, an event on a source whose `irq_en_i` bit is 1 raises `irq_oe_o` on the next clock.
- R5: An event on a source whose `irq_en_i` bit is 0 never raises `irq_oe_o`.
- R6: An enabled event sampled while `bus_busy_i` is high and `irq_oe_o` is low leaves `irq_oe_o` low, even after `bus_busy_i` falls, until `stop_i` is sampled high. `irq_oe_o` then rises on that clock.
- R7: If `irq_oe_o` is already high, it stays high while a transfer is in progress and further events arrive.
- R8: `ara_ack_i` sampled high without a new enabled event drops `irq_oe_o` on the next clock and leaves `status_o` unchanged. The line stays released until a new enabled event arrives.
- R9: After such a release, a new enabled event raises `irq_oe_o` again on the next clock. If the event coincides with `ara_ack_i`, the line stays high.
- R10: When no set status bit remains enabled, `irq_oe_o` drops on the next clock. This happens whether the bits were cleared or their enable bits were cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NSRC | Event strobes, one per source |
| irq_en_i | input | NSRC | Alert enable per source, 1 = enabled |
| clr_i | input | NSRC | Per-bit status clear strobe |
| clr_all_i | input | 1 | Clear all status bits (clear-on-read) |
| bus_busy_i | input | 1 | Serial bus transfer in progress |
| stop_i | input | 1 | Stop condition seen on the bus |
| ara_ack_i | input | 1 | Alert-response address read acknowledged |
| irq_oe_o | output | 1 | Pull-down enable for the open-drain alert line |
| status_o | output | NSRC | Sticky event status |

## Verification
The bench raises an event in the middle of a transfer and then lets `bus_busy_i` fall with no stop. A design that used the busy level alone would pull the line one cycle too early. It also starts a transfer while the line is already low; a design that gated the line with busy would drop an alert the host has not yet seen. It fires an alert-response read on the same cycle as a new event, which a design with clear priority would lose. It also pits clears against same-cycle strobes, which a design with the wrong precedence would turn into a missed event.

// File: rtl/alert_gather.sv
module alert_gather #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] irq_en_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            clr_all_i,
  input  logic            bus_busy_i,
  input  logic            stop_i,
  input  logic            ara_ack_i,
  output logic            irq_oe_o,
  output logic [NSRC-1:0] status_o
);

  logic [NSRC-1:0] stat_q;
  logic            req_q;
  logic            held_q;

  logic [NSRC-1:0] stat_d;
  logic            new_hit;
  logic            keep;
  logic            req_d;
  logic            held_d;

  assign stat_d  = clr_all_i ? evt_i : ((stat_q & ~clr_i) | evt_i);
  assign new_hit = |(evt_i & irq_en_i);
  assign keep    = req_q & ~ara_ack_i & (|(stat_d & irq_en_i));
  assign req_d   = new_hit | keep;
  assign held_d  = req_d & ~stop_i & (held_q | (new_hit & bus_busy_i & ~irq_oe_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      req_q  <= 1'b0;
      held_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      req_q  <= req_d;
      held_q <= held_d;
    end
  end

  assign irq_oe_o = req_q & ~held_q;
  assign status_o = stat_q;

endmodule

// File: rtl/alert_gather_chk.sv
module alert_gather_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] evt_i,
  input logic [NSRC-1:0] irq_en_i,
  input logic [NSRC-1:0] clr_i,
  input logic            clr_all_i,
  input logic            bus_busy_i,
  input logic            stop_i,
  input logic            ara_ack_i,
  input logic            irq_oe_o,
  input logic [NSRC-1:0] status_o,
  input logic            held_q
);

  // R2
  evt_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((status_o & $past(evt_i)) == $past(evt_i)));

  // R3
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all_i |=> ((status_o & $past(status_o & ~clr_i)) == $past(status_o & ~clr_i)));

  // R4
  idle_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(evt_i & irq_en_i)) && !bus_busy_i && !held_q) |=> irq_oe_o);

  // R5
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_oe_o && !held_q && !(|(evt_i & irq_en_i))) |=> !irq_oe_o);

  // R6
  defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !stop_i && !irq_oe_o) |=> !irq_oe_o);

  // R7
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_oe_o && bus_busy_i && (|(evt_i & irq_en_i))) |=> irq_oe_o);

  // R8
  ara_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ara_ack_i && !(|(evt_i & irq_en_i))) |=> !irq_oe_o);

  // R10
  raise_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_oe_o) |-> (|status_o));

endmodule

bind alert_gather alert_gather_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .irq_en_i(irq_en_i), .clr_i(clr_i),
  .clr_all_i(clr_all_i), .bus_busy_i(bus_busy_i), .stop_i(stop_i),
  .ara_ack_i(ara_ack_i), .irq_oe_o(irq_oe_o), .status_o(status_o), .held_q(held_q)
);

// File: tb/sim_alert_gather.sv
module sim_alert_gather;
  localparam int N  = 4;
  localparam int NV = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] evt_i = '0, irq_en_i = '0, clr_i = '0;
  logic clr_all_i = 1'b0, bus_busy_i = 1'b0, stop_i = 1'b0, ara_ack_i = 1'b0;
  logic irq_oe_o;
  logic [N-1:0] status_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alert_gather #(.NSRC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .irq_en_i(irq_en_i), .clr_i(clr_i),
    .clr_all_i(clr_all_i), .bus_busy_i(bus_busy_i), .stop_i(stop_i),
    .ara_ack_i(ara_ack_i), .irq_oe_o(irq_oe_o), .status_o(status_o)
  );

  // req | evt | en | clr | clr_all busy stop ara | exp_oe | exp_status
  localparam logic [24:0] VEC [NV] = '{
    {4'd5,  4'b0100, 4'b0011, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0100}, // R5 R2 masked
    {4'd3,  4'b0000, 4'b0011, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0100}, // R3 sticky
    {4'd4,  4'b0001, 4'b0011, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0101}, // R4 raise
    {4'd8,  4'b0000, 4'b0011, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0101}, // R8 release
    {4'd8,  4'b0000, 4'b0011, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0101}, // R8 stays off
    {4'd9,  4'b0010, 4'b0011, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0111}, // R9 reassert
    {4'd3,  4'b0000, 4'b0011, 4'b0010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0101}, // R3 bit clear
    {4'd10, 4'b0000, 4'b0011, 4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0100}, // R10 drop
    {4'd6,  4'b0001, 4'b0011, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0101}, // R6 deferred
    {4'd6,  4'b0000, 4'b0011, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0101}, // R6 still busy
    {4'd6,  4'b0000, 4'b0011, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0101}, // R6 no stop yet
    {4'd6,  4'b0000, 4'b0011, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0101}, // R6 stop
    {4'd7,  4'b0010, 4'b0011, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0111}, // R7 busy keep
    {4'd7,  4'b0000, 4'b0011, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'b0111}, // R7 end of xfer
    {4'd9,  4'b0001, 4'b0011, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0111}, // R9 ara+event
    {4'd10, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0111}, // R10 disable
    {4'd3,  4'b1000, 4'b0011, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1000}, // R3 set beats clr_all
    {4'd3,  4'b1000, 4'b0011, 4'b1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1000}, // R3 set beats clr
    {4'd3,  4'b0000, 4'b0011, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000}  // R3 clear all
  };

  task automatic check(input int req, input logic eoe, input logic [N-1:0] est);
    checks++;
    if (irq_oe_o !== eoe || status_o !== est) begin
      errors++;
      $display("FAIL R%0d: irq_oe=%b status=%b expected irq_oe=%b status=%b",
               req, irq_oe_o, status_o, eoe, est);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1: watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 1'b0, '0); // R1 during reset
    rst_n = 1'b1;
    @(posedge clk); #2;
    check(1, 1'b0, '0); // R1 after release
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      evt_i      = v[20:17];
      irq_en_i   = v[16:13];
      clr_i      = v[12:9];
      clr_all_i  = v[8];
      bus_busy_i = v[7];
      stop_i     = v[6];
      ara_ack_i  = v[5];
      @(posedge clk); #2;
      check(int'(v[24:21]), v[4], v[3:0]);
      @(negedge clk);
    end
    evt_i = '0; clr_i = '0; clr_all_i = 0; bus_busy_i = 0; stop_i = 0; ara_ack_i = 0;
    // R5 masked source with no enables keeps the line released
    irq_en_i = 4'b0000; evt_i = 4'b1111;
    @(posedge clk); #2; check(5, 1'b0, 4'b1111);
    @(negedge clk); evt_i = '0;
    // R4 enabled event raises the line with one clock of latency
    irq_en_i = 4'b1000; evt_i = 4'b1000;
    @(posedge clk); #2; check(4, 1'b1, 4'b1111);
    @(negedge clk); evt_i = '0;
    // R1 mid-run reset
    rst_n = 1'b0; #1;
    check(1, 1'b0, 4'b0000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2; check(1, 1'b0, 4'b0000);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule